// File: doc/BRIEF.md
# Synthesizer Serial Register Bank

This block is the register file that sits behind the serial port of a fractional-N synthesizer controller. A shifter outside the block assembles each 24-bit word and presents it together with a one-cycle load strobe. The two least significant bits of the word pick one of four registers: divider, reference/modulus, control or noise/spur. The remaining bits are decoded into the fields that steer the rest of the synthesizer: the integer and fractional divide values, the interpolator modulus, the fast-lock timer, the reference count, the control flags and the noise/spur mode.

The modulus is double-buffered. A reference/modulus write only parks a new value as pending, and the next divider write makes it active, so a new channel always starts with a matched FRAC and modulus pair. A load-control flag in the reference/modulus word sends the 12-bit field to the fast-lock timer instead. Every divider write also produces a one-cycle new-channel pulse for the lock detector and the fast-lock timer. Two flags report illegal settings: a zero reference count, and a FRAC that is not strictly below the active modulus.

Top module: `synth_regbank`

## Requirements
- R1: A word is taken only in a cycle with `load_i` high. Bits [1:0] select the target register: 00 divider, 01 reference/modulus, 10 control, 11 noise/spur. A write leaves the other three registers unchanged, and a word offered with `load_i` low changes nothing.
- R2: In a divider word, bits [13:2] are FRAC, bits [22:14] are INT and bit 23 is the fast-lock enable. The three fields appear on `frac_o`, `int_o` and `fastlock_o` from the cycle after the write.
- R3: `new_chan_o` is high for exactly the one cycle that follows each divider write, and it is low after any other cycle.
- R4: In a reference/modulus word with bit 23 = 0, bits [13:2] become the pending modulus and bits [17:14] become the reference count on `rdiv_o`. The active modulus on `mod_o` does not change.
- R5: A divider write copies the pending modulus into `mod_o` at the same clock edge that loads INT and FRAC. `mod_o` changes at no other time.
- R6: In a reference/modulus word with bit 23 = 1, bits [13:2] go to `fl_timer_o`. The pending modulus, the reference count and `mod_o` all stay unchanged.
- R7: `rdiv_err_o` is high whenever the stored reference count is 0, and low for counts 1 to 15.
- R8: `frac_err_o` is high whenever FRAC is greater than or equal to the active modulus.
- R9: The control word maps to outputs as follows: bit 2 `cnt_rst_o`, bit 3 `cp_tristate_o`, bit 4 `pwr_down_o`, bit 5 `ld_prec_o`, bit 6 `pd_pol_o`, bits [10:7] `cp_cur_o`, bit 11 `ref_dbl_o`.
- R10: The noise/spur code is built from word bits {9,8,7,6,2}. On `ns_mode_o`, code 00000 gives 0 (lowest spur), 11100 gives 1 (low noise and spur), 11111 gives 2 (lowest noise), and any other code gives 3. `dither_o` is high only in mode 0. Other bits of the noise/spur word have no effect.
- R11: While `pwr_down_o` is high, all stored values are kept, and words of every kind are still accepted and decoded.
- R12: Reset clears every register. After reset all field outputs are 0, `ns_mode_o` is 0 with `dither_o` high, `new_chan_o` is low, and both error flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe that marks a valid word |
| word_i | input | 24 | Deserialized word, select code in bits [1:0] |
| int_o | output | 9 | Integer divide value |
| frac_o | output | 12 | Fractional value |
| fastlock_o | output | 1 | Fast-lock enable |
| mod_o | output | 12 | Active interpolator modulus |
| fl_timer_o | output | 12 | Fast-lock timer value |
| rdiv_o | output | 4 | Reference division count |
| cnt_rst_o | output | 1 | Counter reset |
| cp_tristate_o | output | 1 | Charge-pump three-state |
| pwr_down_o | output | 1 | Power-down |
| ld_prec_o | output | 1 | Lock-detect precision |
| pd_pol_o | output | 1 | Phase-detector polarity |
| cp_cur_o | output | 4 | Charge-pump current code |
| ref_dbl_o | output | 1 | Reference doubler enable |
| ns_mode_o | output | 2 | Decoded noise/spur mode |
| dither_o | output | 1 | Dither enable |
| new_chan_o | output | 1 | One-cycle pulse after a divider write |
| rdiv_err_o | output | 1 | Reference count is zero |
| frac_err_o | output | 1 | FRAC is not below the active modulus |

## Verification
The hardest state to reach from the ports is a pending modulus that differs from the active one while a timer load happens between the two writes. Nothing on the outputs shows the pending value directly. The stimulus table therefore interleaves modulus writes, timer writes and divider writes with chosen FRAC values. Each divider write then shows, through `mod_o` and `frac_err_o`, which value was pending, including FRAC equal to the modulus and FRAC one below it. A directed sequence repeats the exchange while power-down is set.

// File: rtl/synth_regbank_pkg.sv
package synth_regbank_pkg;

   // Register select codes carried in word bits [1:0].
   typedef enum logic [1:0] {
      SEL_DIV = 2'b00,
      SEL_REF = 2'b01,
      SEL_CTL = 2'b10,
      SEL_NS  = 2'b11
   } sel_e;

   // Decoded noise/spur modes.
   typedef enum logic [1:0] {
      NS_LOWEST_SPUR    = 2'd0,
      NS_LOW_NOISE_SPUR = 2'd1,
      NS_LOWEST_NOISE   = 2'd2,
      NS_UNKNOWN        = 2'd3
   } ns_mode_e;

   // Control word occupies bits [CTL_HI:CTL_LO]; packed so that the MSB is bit 11.
   localparam int CTL_LO = 2;
   localparam int CTL_HI = 11;

   typedef struct packed {
      logic       ref_dbl;    // bit 11
      logic [3:0] cp_cur;     // bits 10:7
      logic       pd_pol;     // bit 6
      logic       ld_prec;    // bit 5
      logic       pwr_dn;     // bit 4
      logic       cp_3state;  // bit 3
      logic       cnt_rst;    // bit 2
   } ctl_t;

   // Noise/spur code positions, most significant first.
   localparam int NS_B4 = 9;
   localparam int NS_B3 = 8;
   localparam int NS_B2 = 7;
   localparam int NS_B1 = 6;
   localparam int NS_B0 = 2;

   localparam logic [4:0] NS_CODE_SPUR  = 5'b00000;
   localparam logic [4:0] NS_CODE_MIX   = 5'b11100;
   localparam logic [4:0] NS_CODE_NOISE = 5'b11111;

endpackage

// File: rtl/srb_addr_dec.sv
module srb_addr_dec #(
   parameter int SEL_W = 2
) (
   input  logic                  load_i,
   input  logic [SEL_W-1:0]      sel_i,
   output logic [(1<<SEL_W)-1:0] wr_o
);
   localparam int NREG = 1 << SEL_W;

   for (genvar i = 0; i < NREG; i++) begin : g_strobe
      localparam logic [SEL_W-1:0] CODE = SEL_W'(i);
      assign wr_o[i] = load_i && (sel_i == CODE);
   end
endmodule

// File: rtl/srb_mod_buf.sv
module srb_mod_buf #(
   parameter int MOD_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ref_i,
   input  logic             wr_div_i,
   input  logic             to_timer_i,
   input  logic [MOD_W-1:0] field_i,
   output logic [MOD_W-1:0] pend_o,
   output logic [MOD_W-1:0] act_o,
   output logic [MOD_W-1:0] timer_o
);
   logic [MOD_W-1:0] pend_q, act_q, timer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         act_q   <= '0;
         timer_q <= '0;
      end else begin
         if (wr_ref_i) begin
            if (to_timer_i) timer_q <= field_i;
            else            pend_q  <= field_i;
         end
         if (wr_div_i) act_q <= pend_q;
      end
   end

   assign pend_o  = pend_q;
   assign act_o   = act_q;
   assign timer_o = timer_q;
endmodule

// File: rtl/srb_flags.sv
module srb_flags #(
   parameter int FRAC_W    = 12,
   parameter int RDIV_W    = 4,
   parameter bit REG_FLAGS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [FRAC_W-1:0] mod_i,
   input  logic [RDIV_W-1:0] rdiv_i,
   output logic              frac_err_o,
   output logic              rdiv_err_o
);
   logic frac_bad, rdiv_bad;

   always_comb begin
      frac_bad = (frac_i >= mod_i);
      rdiv_bad = (rdiv_i == '0);
   end

   if (REG_FLAGS) begin : g_reg
      logic frac_q, rdiv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            frac_q <= 1'b1;
            rdiv_q <= 1'b1;
         end else begin
            frac_q <= frac_bad;
            rdiv_q <= rdiv_bad;
         end
      end
      assign frac_err_o = frac_q;
      assign rdiv_err_o = rdiv_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign frac_err_o = frac_bad;
      assign rdiv_err_o = rdiv_bad;
   end
endmodule

// File: rtl/srb_ns_decode.sv
module srb_ns_decode
   import synth_regbank_pkg::*;
(
   input  logic [4:0] code_i,
   output logic [1:0] mode_o,
   output logic       dither_o
);
   ns_mode_e mode;

   always_comb begin
      unique case (code_i)
         NS_CODE_SPUR:  mode = NS_LOWEST_SPUR;
         NS_CODE_MIX:   mode = NS_LOW_NOISE_SPUR;
         NS_CODE_NOISE: mode = NS_LOWEST_NOISE;
         default:       mode = NS_UNKNOWN;
      endcase
   end

   assign mode_o   = mode;
   assign dither_o = (mode == NS_LOWEST_SPUR);
endmodule

// File: rtl/synth_regbank.sv
module synth_regbank
   import synth_regbank_pkg::*;
#(
   parameter int WORD_W    = 24,
   parameter int INT_W     = 9,
   parameter int FRAC_W    = 12,
   parameter int RDIV_W    = 4,
   parameter int RDIV_LO   = 14,
   parameter bit REG_FLAGS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [INT_W-1:0]  int_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic              fastlock_o,
   output logic [FRAC_W-1:0] mod_o,
   output logic [FRAC_W-1:0] fl_timer_o,
   output logic [RDIV_W-1:0] rdiv_o,
   output logic              cnt_rst_o,
   output logic              cp_tristate_o,
   output logic              pwr_down_o,
   output logic              ld_prec_o,
   output logic              pd_pol_o,
   output logic [3:0]        cp_cur_o,
   output logic              ref_dbl_o,
   output logic [1:0]        ns_mode_o,
   output logic              dither_o,
   output logic              new_chan_o,
   output logic              rdiv_err_o,
   output logic              frac_err_o
);
   localparam int SEL_W   = 2;
   localparam int FRAC_LO = SEL_W;
   localparam int FRAC_HI = FRAC_LO + FRAC_W - 1;
   localparam int INT_LO  = FRAC_HI + 1;
   localparam int INT_HI  = INT_LO + INT_W - 1;
   localparam int TOP_BIT = WORD_W - 1;
   localparam int RDIV_HI = RDIV_LO + RDIV_W - 1;

   // Elaboration-time parameter checks.
   if (WORD_W < 24) begin : g_bad_word
      $error("synth_regbank: WORD_W must be at least 24");
   end
   if (INT_HI >= TOP_BIT) begin : g_bad_int
      $error("synth_regbank: INT field overlaps the fast-lock bit");
   end
   if (RDIV_LO <= FRAC_HI || RDIV_HI >= TOP_BIT) begin : g_bad_rdiv
      $error("synth_regbank: reference count field misplaced");
   end

   // Write strobes.
   logic [(1<<SEL_W)-1:0] wr;
   logic wr_div, wr_ref, wr_ctl, wr_ns;

   srb_addr_dec #(.SEL_W(SEL_W)) u_dec (
      .load_i (load_i),
      .sel_i  (word_i[SEL_W-1:0]),
      .wr_o   (wr)
   );

   assign wr_div = wr[SEL_DIV];
   assign wr_ref = wr[SEL_REF];
   assign wr_ctl = wr[SEL_CTL];
   assign wr_ns  = wr[SEL_NS];

   logic to_timer;
   assign to_timer = word_i[TOP_BIT];

   // Divider, reference count, control and noise/spur storage.
   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   logic              fl_q;
   logic [RDIV_W-1:0] rdiv_q;
   ctl_t              ctl_q;
   logic [4:0]        ns_q;
   logic              new_chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q      <= '0;
         frac_q     <= '0;
         fl_q       <= 1'b0;
         rdiv_q     <= '0;
         ctl_q      <= '0;
         ns_q       <= '0;
         new_chan_q <= 1'b0;
      end else begin
         new_chan_q <= wr_div;
         if (wr_div) begin
            int_q  <= word_i[INT_HI:INT_LO];
            frac_q <= word_i[FRAC_HI:FRAC_LO];
            fl_q   <= word_i[TOP_BIT];
         end
         if (wr_ref && !to_timer) rdiv_q <= word_i[RDIV_HI:RDIV_LO];
         if (wr_ctl) ctl_q <= ctl_t'(word_i[CTL_HI:CTL_LO]);
         if (wr_ns)  ns_q  <= {word_i[NS_B4], word_i[NS_B3], word_i[NS_B2],
                               word_i[NS_B1], word_i[NS_B0]};
      end
   end

   // Double-buffered modulus and fast-lock timer.
   logic [FRAC_W-1:0] mod_pend, mod_act, timer;

   srb_mod_buf #(.MOD_W(FRAC_W)) u_mod (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ref_i   (wr_ref),
      .wr_div_i   (wr_div),
      .to_timer_i (to_timer),
      .field_i    (word_i[FRAC_HI:FRAC_LO]),
      .pend_o     (mod_pend),
      .act_o      (mod_act),
      .timer_o    (timer)
   );

   srb_flags #(
      .FRAC_W    (FRAC_W),
      .RDIV_W    (RDIV_W),
      .REG_FLAGS (REG_FLAGS)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .frac_i     (frac_q),
      .mod_i      (mod_act),
      .rdiv_i     (rdiv_q),
      .frac_err_o (frac_err_o),
      .rdiv_err_o (rdiv_err_o)
   );

   srb_ns_decode u_ns (
      .code_i   (ns_q),
      .mode_o   (ns_mode_o),
      .dither_o (dither_o)
   );

   assign int_o         = int_q;
   assign frac_o        = frac_q;
   assign fastlock_o    = fl_q;
   assign mod_o         = mod_act;
   assign fl_timer_o    = timer;
   assign rdiv_o        = rdiv_q;
   assign cnt_rst_o     = ctl_q.cnt_rst;
   assign cp_tristate_o = ctl_q.cp_3state;
   assign pwr_down_o    = ctl_q.pwr_dn;
   assign ld_prec_o     = ctl_q.ld_prec;
   assign pd_pol_o      = ctl_q.pd_pol;
   assign cp_cur_o      = ctl_q.cp_cur;
   assign ref_dbl_o     = ctl_q.ref_dbl;
   assign new_chan_o    = new_chan_q;
endmodule

// File: rtl/synth_regbank_chk.sv
module synth_regbank_chk #(
   parameter int WORD_W    = 24,
   parameter int MOD_W     = 12,
   parameter int INT_W     = 9,
   parameter int RDIV_W    = 4,
   parameter int RDIV_LO   = 14,
   parameter bit REG_FLAGS = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [WORD_W-1:0] word_i,
   input logic [MOD_W-1:0]  mod_pend,
   input logic [MOD_W-1:0]  mod_o,
   input logic [MOD_W-1:0]  fl_timer_o,
   input logic [MOD_W-1:0]  frac_o,
   input logic [INT_W-1:0]  int_o,
   input logic [RDIV_W-1:0] rdiv_o,
   input logic              new_chan_o,
   input logic              rdiv_err_o,
   input logic              frac_err_o
);
   logic div_w, ref_w, ldc;
   assign div_w = load_i && (word_i[1:0] == 2'b00);
   assign ref_w = load_i && (word_i[1:0] == 2'b01);
   assign ldc   = word_i[WORD_W-1];

   assert_keep_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !div_w |=> ($stable(int_o) && $stable(frac_o)));

   assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      div_w |=> new_chan_o);

   assert_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !div_w |=> !new_chan_o);

   assert_mod_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !div_w |=> $stable(mod_o));

   assert_mod_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      div_w |=> (mod_o == $past(mod_pend)));

   assert_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_w && ldc) |=> ((fl_timer_o == $past(word_i[MOD_W+1:2]))
                          && $stable(mod_pend) && $stable(rdiv_o)));

   if (!REG_FLAGS) begin : g_comb_flags
      assert_rzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (ref_w && !ldc && (word_i[RDIV_LO+RDIV_W-1:RDIV_LO] == '0)) |=> rdiv_err_o);

      assert_frac_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (div_w && (word_i[MOD_W+1:2] >= mod_pend)) |=> frac_err_o);
   end
endmodule

bind synth_regbank synth_regbank_chk #(
   .WORD_W    (WORD_W),
   .MOD_W     (FRAC_W),
   .INT_W     (INT_W),
   .RDIV_W    (RDIV_W),
   .RDIV_LO   (RDIV_LO),
   .REG_FLAGS (REG_FLAGS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_i     (load_i),
   .word_i     (word_i),
   .mod_pend   (mod_pend),
   .mod_o      (mod_o),
   .fl_timer_o (fl_timer_o),
   .frac_o     (frac_o),
   .int_o      (int_o),
   .rdiv_o     (rdiv_o),
   .new_chan_o (new_chan_o),
   .rdiv_err_o (rdiv_err_o),
   .frac_err_o (frac_err_o)
);

// File: tb/synth_regbank_bench.sv
module synth_regbank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 54;
   localparam int NVEC = 8;

   // Fields: kind(1=divider,0=ref) | ldc | a9 (INT or R) | b12 (FRAC or modulus/timer) | fl |
   //         exp_mod12 | exp_timer12 | exp_rdiv4 | exp_ferr | exp_rerr
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {1'b0,1'b0,9'd5,  12'd100, 1'b0,12'd0,   12'd0,  4'd5, 1'b1,1'b0},
      {1'b1,1'b0,9'd50, 12'd40,  1'b1,12'd100, 12'd0,  4'd5, 1'b0,1'b0},
      {1'b0,1'b1,9'd0,  12'd300, 1'b0,12'd100, 12'd300,4'd5, 1'b0,1'b0},
      {1'b1,1'b0,9'd60, 12'd99,  1'b0,12'd100, 12'd300,4'd5, 1'b0,1'b0},
      {1'b0,1'b0,9'd0,  12'd50,  1'b0,12'd100, 12'd300,4'd0, 1'b0,1'b1},
      {1'b1,1'b0,9'd511,12'd50,  1'b1,12'd50,  12'd300,4'd0, 1'b1,1'b1},
      {1'b0,1'b0,9'd15, 12'd4095,1'b0,12'd50,  12'd300,4'd15,1'b1,1'b0},
      {1'b1,1'b0,9'd31, 12'd4094,1'b0,12'd4095,12'd300,4'd15,1'b0,1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [23:0] word_i = '0;
   logic [8:0]  int_o;
   logic [11:0] frac_o, mod_o, fl_timer_o;
   logic [3:0]  rdiv_o, cp_cur_o;
   logic [1:0]  ns_mode_o;
   logic fastlock_o, cnt_rst_o, cp_tristate_o, pwr_down_o, ld_prec_o, pd_pol_o;
   logic ref_dbl_o, dither_o, new_chan_o, rdiv_err_o, frac_err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   synth_regbank u_synth_regbank (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i),
      .int_o(int_o), .frac_o(frac_o), .fastlock_o(fastlock_o), .mod_o(mod_o),
      .fl_timer_o(fl_timer_o), .rdiv_o(rdiv_o), .cnt_rst_o(cnt_rst_o),
      .cp_tristate_o(cp_tristate_o), .pwr_down_o(pwr_down_o), .ld_prec_o(ld_prec_o),
      .pd_pol_o(pd_pol_o), .cp_cur_o(cp_cur_o), .ref_dbl_o(ref_dbl_o),
      .ns_mode_o(ns_mode_o), .dither_o(dither_o), .new_chan_o(new_chan_o),
      .rdiv_err_o(rdiv_err_o), .frac_err_o(frac_err_o)
   );

   function automatic logic [23:0] divw(input logic [8:0] i, input logic [11:0] f, input logic fl);
      return {fl, i, f, 2'b00};
   endfunction
   function automatic logic [23:0] refw(input logic ldc, input logic [3:0] r, input logic [11:0] m);
      return {ldc, 5'b0, r, m, 2'b01};
   endfunction
   function automatic logic [23:0] ctlw(input logic [9:0] bits);
      return {12'b0, bits, 2'b10};
   endfunction
   function automatic logic [23:0] nsw(input logic [4:0] c, input logic extra);
      return {13'b0, extra, c[4:1], 3'b0, c[0], 2'b11};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Apply one word for one cycle; returns at the following falling edge.
   task automatic put(input logic [23:0] w);
      @(negedge clk);
      word_i = w;
      load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      load_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic reset_checks();
      chk("R12 int", int_o, 0);
      chk("R12 frac", frac_o, 0);
      chk("R12 mod", mod_o, 0);
      chk("R12 timer", fl_timer_o, 0);
      chk("R12 rdiv", rdiv_o, 0);
      chk("R12 ctl", {cnt_rst_o,cp_tristate_o,pwr_down_o,ld_prec_o,pd_pol_o,cp_cur_o,ref_dbl_o}, 0);
      chk("R12 mode", ns_mode_o, 0);
      chk("R12 dither", dither_o, 1);
      chk("R12 new_chan", new_chan_o, 0);
      chk("R12 rdiv_err", rdiv_err_o, 1);
      chk("R12 frac_err", frac_err_o, 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      do_reset();
      reset_checks();

      // Table of interleaved divider / reference writes (R2 R3 R4 R5 R6 R7 R8).
      for (int k = 0; k < NVEC; k++) begin
         logic [VW-1:0] v;
         v = VEC[k];
         if (v[53]) put(divw(v[51:43], v[42:31], v[30]));
         else       put(refw(v[52], v[46:43], v[42:31]));
         chk("R5 mod", mod_o, v[29:18]);
         chk("R6 timer", fl_timer_o, v[17:6]);
         chk("R4 rdiv", rdiv_o, v[5:2]);
         chk("R8 frac_err", frac_err_o, v[1]);
         chk("R7 rdiv_err", rdiv_err_o, v[0]);
         chk("R3 new_chan", new_chan_o, v[53]);
         if (v[53]) begin
            chk("R2 int", int_o, v[51:43]);
            chk("R2 frac", frac_o, v[42:31]);
            chk("R2 fastlock", fastlock_o, v[30]);
         end
      end
      @(negedge clk);
      chk("R3 pulse drops", new_chan_o, 0);

      // R1: word offered without load is ignored.
      word_i = divw(9'd7, 12'd7, 1'b1);
      @(negedge clk);
      @(negedge clk);
      chk("R1 no load int", int_o, 31);
      chk("R1 no load frac", frac_o, 4094);

      // R9: control bits, and R1: other registers untouched.
      put(ctlw(10'b1_1010_0_1_0_1_0));
      chk("R9 ref_dbl", ref_dbl_o, 1);
      chk("R9 cp_cur", cp_cur_o, 4'b1010);
      chk("R9 pd_pol", pd_pol_o, 0);
      chk("R9 ld_prec", ld_prec_o, 1);
      chk("R9 pwr_down", pwr_down_o, 0);
      chk("R9 cp_tristate", cp_tristate_o, 1);
      chk("R9 cnt_rst", cnt_rst_o, 0);
      chk("R1 ctl keeps int", int_o, 31);
      chk("R1 ctl keeps mod", mod_o, 4095);
      chk("R3 no pulse on ctl", new_chan_o, 0);
      put(ctlw(10'b0_0101_1_0_0_0_1));
      chk("R9 cnt_rst set", cnt_rst_o, 1);
      chk("R9 pd_pol set", pd_pol_o, 1);
      chk("R9 cp_cur 0101", cp_cur_o, 4'b0101);

      // R11: power-down keeps contents and still accepts words.
      put(ctlw(10'b0_0000_0_0_1_0_0));
      chk("R11 pwr_down", pwr_down_o, 1);
      chk("R11 kept int", int_o, 31);
      chk("R11 kept timer", fl_timer_o, 300);
      put(refw(1'b0, 4'd3, 12'd200));
      chk("R11 ref accepted", rdiv_o, 3);
      chk("R11 mod still old", mod_o, 4095);
      put(divw(9'd100, 12'd199, 1'b0));
      chk("R11 int accepted", int_o, 100);
      chk("R11 mod swapped", mod_o, 200);
      chk("R11 frac_err", frac_err_o, 0);
      chk("R11 still down", pwr_down_o, 1);

      // R10: noise/spur decode.
      put(nsw(5'b11100, 1'b0));
      chk("R10 mix mode", ns_mode_o, 1);
      chk("R10 mix dither", dither_o, 0);
      put(nsw(5'b11111, 1'b1));
      chk("R10 noise mode (extra bit ignored)", ns_mode_o, 2);
      chk("R10 noise dither", dither_o, 0);
      put(nsw(5'b10000, 1'b0));
      chk("R10 unknown mode", ns_mode_o, 3);
      chk("R10 unknown dither", dither_o, 0);
      put(nsw(5'b00000, 1'b1));
      chk("R10 spur mode", ns_mode_o, 0);
      chk("R10 spur dither", dither_o, 1);
      chk("R1 ns keeps ctl", pwr_down_o, 1);

      // R12: reset in the middle of operation.
      do_reset();
      reset_checks();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule